// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with Latched Output Pin

This block is an 8-bit down counter paced by a 7-bit down-counting prescaler. Software reaches it through three byte-wide registers on a plain select/strobe bus: a prescaler register, a counter register and a control register. A 3-bit field in the control register picks a power-of-two prescale ratio from 1 to 128. Each time the counter steps from one to zero it sets a sticky zero flag. The flag raises an interrupt request when interrupts are enabled, and it stays set until software clears it.

The timer can also drive a pin. In output mode the pin follows a software data bit while the zero flag is high. When the flag drops, the pin keeps the last value it had. Software can force the zero flag in two ways: by loading zero into the counter, or by writing the flag bit directly. A bus write to the counter always takes priority over a decrement in the same cycle.

Top module: `tick_down_timer`

## Requirements
- R1: After reset the prescaler reads 0x7F, the counter reads 0xFF and the control register reads 0x00. `irq`, `pin_oe` and `pin_out` are all 0.
- R2: While the run bit (control bit 3) is 0, the prescaler is held at 0x7F, the counter does not change, and writes to the prescaler have no effect.
- R3: While the run bit is 1, the prescaler decreases by one every cycle and wraps from 0x00 to 0x7F. A prescaler write loads `wr_data[6:0]` in place of that step. Bit 7 of a prescaler read is always 0.
- R4: With divide code n in control bits 2..0, the counter decreases by one in each running cycle in which the low n bits of the prescaler are all zero. The counter therefore steps once every 2^n cycles (code 0 steps every cycle, code 7 every 128 cycles), unless that cycle carries a prescaler write.
- R5: A counter step from 0x00 gives 0xFF and counting continues. That step does not set the zero flag.
- R6: A counter step from 0x01 to 0x00 sets the zero flag (control bit 7).
- R7: The zero flag is also set by writing 0x00 to the counter, or by a control write with bit 7 = 1. A control write with bit 7 = 0 clears the flag, unless the flag is set by hardware in the same cycle, in which case the set wins.
- R8: A counter write in the same cycle as a step that would reach zero loads the written value and does not set the zero flag.
- R9: `irq` is 1 exactly when the zero flag and the interrupt enable bit (control bit 6) are both 1.
- R10: In output mode (control bit 5 = 1), `pin_oe` is 1. While the zero flag is high, `pin_out` equals the data bit (control bit 4). While the flag is low, `pin_out` holds the data bit from the last cycle in which the flag was high (0 if the flag has never been high).
- R11: In input mode (control bit 5 = 0), `pin_oe` and `pin_out` are both 0.
- R12: `reg_sel` 0 selects the prescaler, 1 the counter, 2 the control register, and 3 selects nothing (reads 0x00, writes are ignored). Reads are combinational from `reg_sel`. A write takes effect on the clock edge where `wr_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |
| pin_out | output | 1 | Timer pin value |
| pin_oe | output | 1 | Timer pin output enable |

## Verification
The in-module assertions check local cycle-to-cycle rules on every cycle:
- the prescaler is held at 0x7F when stopped and steps by one when running;
- the counter does not move without a tick or a write;
- a counter write wins over a simultaneous step;
- the counter wraps from zero to 0xFF;
- a step from one sets the zero flag;
- the pin keeps the last data bit when the flag falls.

Some behaviours only the bench's scenarios can show, through a reference model compared after every cycle:
- whether the tick rate matches the selected divide code over long runs;
- how the two software ways of forcing the flag interact with hardware setting it;
- whether interrupt and pin outputs stay correct across random mixes of writes and mode changes.

// File: rtl/tdt_pkg.sv
package tdt_pkg;

  localparam int unsigned DIV_SEL_W = 3;

  typedef enum logic [1:0] {
    REG_PRESCALE = 2'd0,
    REG_COUNT    = 2'd1,
    REG_CTRL     = 2'd2,
    REG_NONE     = 2'd3
  } reg_sel_e;

  // Control register layout; bit positions are decoded by software.
  typedef struct packed {
    logic                 zero;
    logic                 irq_en;
    logic                 out_mode;
    logic                 out_data;
    logic                 run;
    logic [DIV_SEL_W-1:0] div;
  } ctrl_t;

endpackage

// File: rtl/tdt_prescaler.sv
module tdt_prescaler #(
  parameter int unsigned PSC_W = 7,
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             load,
  input  logic [PSC_W-1:0] load_val,
  output logic [PSC_W-1:0] psc_q,
  output logic             tick
);

  logic [PSC_W-1:0] tap_mask;

  // Select which low bits must all be zero for a tick.
  always_comb begin
    for (int i = 0; i < PSC_W; i++) begin
      tap_mask[i] = (i < int'(div));
    end
  end

  assign tick = run && !load && ((psc_q & tap_mask) == '0);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      psc_q <= '1;
    end else if (load) begin
      psc_q <= load_val;
    end else begin
      psc_q <= psc_q - 1'b1;
    end
  end

  a_r2_psc_held: assert property (@(posedge clk) disable iff (rst)
    !run |=> psc_q == '1);

  a_r3_psc_step: assert property (@(posedge clk) disable iff (rst)
    run && !load |=> psc_q == $past(psc_q) - 1'b1);

endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             flag_wr,
  input  logic             flag_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             zero_q
);

  logic reach_zero;
  logic hw_set;

  assign reach_zero = tick && !cnt_wr && (cnt_q == CNT_W'(1));
  assign hw_set     = reach_zero || (cnt_wr && (wr_val == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
    end else if (cnt_wr) begin
      cnt_q <= wr_val;
    end else if (tick) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // A hardware set wins over a software clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      zero_q <= 1'b0;
    end else if (hw_set) begin
      zero_q <= 1'b1;
    end else if (flag_wr) begin
      zero_q <= flag_val;
    end
  end

  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> cnt_q == $past(wr_val));

  a_r6_zero_sets_flag: assert property (@(posedge clk) disable iff (rst)
    tick && !cnt_wr && cnt_q == CNT_W'(1) |=> zero_q);

  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    tick && !cnt_wr && cnt_q == '0 |=> cnt_q == '1);

  a_r2_count_stable: assert property (@(posedge clk) disable iff (rst)
    !tick && !cnt_wr |=> $stable(cnt_q));

endmodule

// File: rtl/tdt_pin_latch.sv
module tdt_pin_latch (
  input  logic clk,
  input  logic rst,
  input  logic flag,
  input  logic out_mode,
  input  logic dout,
  output logic pin_out,
  output logic pin_oe
);

  logic hold_q;

  // Flop-based equivalent of a latch transparent while flag is high.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
    end else if (flag) begin
      hold_q <= dout;
    end
  end

  assign pin_oe  = out_mode;
  assign pin_out = out_mode && (flag ? dout : hold_q);

  a_r10_hold_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) && out_mode |-> pin_out == $past(dout));

endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import tdt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              pin_out,
  output logic              pin_oe
);

  localparam int unsigned PSC_W = DATA_W - 1;

  logic                 psc_wr, cnt_wr, ctrl_wr;
  logic                 irq_en_q, out_mode_q, out_data_q, run_q;
  logic [DIV_SEL_W-1:0] div_q;
  logic [PSC_W-1:0]     psc_q;
  logic [DATA_W-1:0]    cnt_q;
  logic                 tick, zero_q;
  ctrl_t                wr_ctrl, ctrl_view;

  assign psc_wr  = wr_en && (reg_sel == REG_PRESCALE);
  assign cnt_wr  = wr_en && (reg_sel == REG_COUNT);
  assign ctrl_wr = wr_en && (reg_sel == REG_CTRL);
  assign wr_ctrl = ctrl_t'(wr_data[7:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en_q   <= 1'b0;
      out_mode_q <= 1'b0;
      out_data_q <= 1'b0;
      run_q      <= 1'b0;
      div_q      <= '0;
    end else if (ctrl_wr) begin
      irq_en_q   <= wr_ctrl.irq_en;
      out_mode_q <= wr_ctrl.out_mode;
      out_data_q <= wr_ctrl.out_data;
      run_q      <= wr_ctrl.run;
      div_q      <= wr_ctrl.div;
    end
  end

  tdt_prescaler #(.PSC_W(PSC_W), .DIV_W(DIV_SEL_W)) u_prescaler (
    .clk      (clk),
    .rst      (rst),
    .run      (run_q),
    .div      (div_q),
    .load     (psc_wr),
    .load_val (wr_data[PSC_W-1:0]),
    .psc_q    (psc_q),
    .tick     (tick)
  );

  tdt_counter #(.CNT_W(DATA_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cnt_wr   (cnt_wr),
    .wr_val   (wr_data),
    .flag_wr  (ctrl_wr),
    .flag_val (wr_ctrl.zero),
    .cnt_q    (cnt_q),
    .zero_q   (zero_q)
  );

  tdt_pin_latch u_pin (
    .clk      (clk),
    .rst      (rst),
    .flag     (zero_q),
    .out_mode (out_mode_q),
    .dout     (out_data_q),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  assign irq = zero_q && irq_en_q;

  always_comb begin
    ctrl_view = '{zero: zero_q, irq_en: irq_en_q, out_mode: out_mode_q,
                  out_data: out_data_q, run: run_q, div: div_q};
    case (reg_sel)
      REG_PRESCALE: rd_data = {1'b0, psc_q};
      REG_COUNT:    rd_data = cnt_q;
      REG_CTRL:     rd_data = ctrl_view;
      default:      rd_data = '0;
    endcase
  end

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && !wr_ctrl.irq_en |=> !irq);

endmodule

// File: tb/test_tick_down_timer.sv
`timescale 1ns/100ps
module test_tick_down_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq, pin_out, pin_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [6:0] m_psc;
  logic [7:0] m_cnt;
  logic [7:0] m_st;
  logic       m_hold;

  always #4 clk = ~clk;

  tick_down_timer i_tick_down_timer (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rd_now(input logic [1:0] s);
    return 8'h00;
  endfunction

  task automatic peek(input logic [1:0] s, output logic [7:0] v);
    reg_sel = s;
    #0.2;
    v = rd_data;
  endtask

  // Reference model, written from the requirements.
  task automatic model_step(input bit we, input logic [1:0] s, input logic [7:0] d);
    logic       pw, cw, sw, tk, hw;
    logic [6:0] mask;
    logic [7:0] n_cnt, n_st;
    logic [6:0] n_psc;
    pw = we && s == 2'd0;
    cw = we && s == 2'd1;
    sw = we && s == 2'd2;
    mask = 7'((8'd1 << m_st[2:0]) - 8'd1);
    tk = m_st[3] && !pw && ((m_psc & mask) == 7'd0);
    n_psc = !m_st[3] ? 7'h7F : (pw ? d[6:0] : m_psc - 7'd1);
    n_cnt = cw ? d : (tk ? m_cnt - 8'd1 : m_cnt);
    hw = (tk && !cw && m_cnt == 8'd1) || (cw && d == 8'd0);
    n_st = sw ? d : m_st;
    n_st[7] = n_st[7] | hw;
    if (m_st[7]) m_hold = m_st[4];
    m_psc = n_psc;
    m_cnt = n_cnt;
    m_st  = n_st;
  endtask

  task automatic compare_all();
    logic [7:0] v;
    logic       exp_pin;
    peek(2'd0, v); chk("R3 prescaler", v, {1'b0, m_psc});
    peek(2'd1, v); chk("R4 counter", v, m_cnt);
    peek(2'd2, v); chk("R7 control", v, m_st);
    chk("R9 irq", {7'd0, irq}, {7'd0, m_st[7] & m_st[6]});
    exp_pin = m_st[5] && (m_st[7] ? m_st[4] : m_hold);
    if (m_st[5]) begin
      chk("R10 pin_oe", {7'd0, pin_oe}, 8'd1);
      chk("R10 pin_out", {7'd0, pin_out}, {7'd0, exp_pin});
    end else begin
      chk("R11 pin_oe", {7'd0, pin_oe}, 8'd0);
      chk("R11 pin_out", {7'd0, pin_out}, 8'd0);
    end
  endtask

  task automatic do_cycle(input bit we, input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = we; reg_sel = s; wr_data = d;
    @(posedge clk);
    model_step(we, s, d);
    #1;
    wr_en = 1'b0;
    compare_all();
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    m_psc = 7'h7F; m_cnt = 8'hFF; m_st = 8'h00; m_hold = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    peek(2'd0, v); chk("R1 prescaler reset", v, 8'h7F);
    peek(2'd1, v); chk("R1 counter reset", v, 8'hFF);
    peek(2'd2, v); chk("R1 control reset", v, 8'h00);
    chk("R1 irq reset", {7'd0, irq}, 8'd0);
    chk("R1 pin_oe reset", {7'd0, pin_oe}, 8'd0);
    chk("R1 pin_out reset", {7'd0, pin_out}, 8'd0);
    // R12 unused select reads zero, write ignored
    peek(2'd3, v); chk("R12 unused select", v, 8'h00);
    do_cycle(1'b1, 2'd3, 8'hFF);
    // R2 stopped: prescaler write ignored, counter still
    do_cycle(1'b1, 2'd0, 8'h12);
    peek(2'd0, v); chk("R2 prescaler held", v, 8'h7F);
    repeat (3) do_cycle(1'b0, 2'd0, 8'h00);
    peek(2'd1, v); chk("R2 counter still", v, 8'hFF);
    // Run, divide by 1, count down to zero: R6
    do_cycle(1'b1, 2'd2, 8'h08);
    do_cycle(1'b1, 2'd1, 8'h03);
    repeat (3) do_cycle(1'b0, 2'd0, 8'h00);
    peek(2'd2, v); chk("R6 flag after reaching zero", {7'd0, v[7]}, 8'd1);
    // Clear flag in the same edge the counter wraps: R5
    do_cycle(1'b1, 2'd2, 8'h08);
    peek(2'd1, v); chk("R5 wrap to FF", v, 8'hFF);
    peek(2'd2, v); chk("R5 no flag on wrap", {7'd0, v[7]}, 8'd0);
    // R8: write wins over a step to zero
    do_cycle(1'b1, 2'd1, 8'h01);
    do_cycle(1'b1, 2'd1, 8'h40);
    peek(2'd1, v); chk("R8 written value", v, 8'h40);
    peek(2'd2, v); chk("R8 flag not set", {7'd0, v[7]}, 8'd0);
    // R7: forcing the flag
    do_cycle(1'b1, 2'd1, 8'h00);
    peek(2'd2, v); chk("R7 zero write sets flag", {7'd0, v[7]}, 8'd1);
    do_cycle(1'b1, 2'd2, 8'h00);
    do_cycle(1'b1, 2'd2, 8'h80);
    peek(2'd2, v); chk("R7 control write sets flag", {7'd0, v[7]}, 8'd1);
    // R10: pin follows then holds
    do_cycle(1'b1, 2'd2, 8'hB8);
    chk("R10 pin follows data", {7'd0, pin_out}, 8'd1);
    do_cycle(1'b1, 2'd2, 8'h28);
    chk("R10 pin holds after fall", {7'd0, pin_out}, 8'd1);
    // R9: interrupt
    do_cycle(1'b1, 2'd2, 8'hC8);
    chk("R9 irq raised", {7'd0, irq}, 8'd1);
    // R4: divide by 8
    do_cycle(1'b1, 2'd2, 8'h0B);
    do_cycle(1'b1, 2'd1, 8'h05);
    repeat (40) do_cycle(1'b0, 2'd0, 8'h00);
    // R3: prescaler load while running
    do_cycle(1'b1, 2'd0, 8'hA5);
    peek(2'd0, v); chk("R3 prescaler load", v, 8'h25);
    // Random mix
    for (int k = 0; k < 4000; k++) begin
      int unsigned r;
      logic [1:0] s;
      logic [7:0] d;
      r = $urandom % 10;
      s = 2'($urandom % 4);
      d = 8'($urandom);
      if (s == 2'd2) begin
        d[7] = ($urandom % 6 == 0);
        d[3] = ($urandom % 5 != 0);
        d[2:0] = ($urandom % 3 != 0) ? 3'($urandom % 3) : 3'($urandom % 8);
      end else if (s == 2'd1 && ($urandom % 2 == 0)) begin
        d = 8'($urandom % 6);
      end
      do_cycle(r < 2, s, d);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule